// File: doc/BRIEF.md
# Decimal Fractional Phase Accumulator

This block is the phase computer of a fractional-N frequency synthesizer whose comparison reference runs at 100 kHz, so one reference frame lasts 10 µs. Each frame, the programmed output frequency multiplied by 10 µs gives the number of oscillator cycles that must elapse in the frame. That number has a whole part and a fractional part. The frequency arrives as an eight-digit BCD word in hertz, so the top three digits are the whole-cycle count and the low five digits are the fraction, in units of 10⁻⁵ cycle. The block keeps a decimal fraction register across frames. Each frame it adds the new fractional increment to that register. Whenever the decimal sum passes one full cycle, it borrows one extra cycle for that frame. The divider therefore receives either N or N+1 cycles, and the correction stage receives the fractional residue left over.

A mode input picks the transmit or receive frequency format. In receive mode the programmed frequency is raised by 200 kHz, which adds two whole cycles per frame and leaves the fraction untouched. The frequency word and the mode are sampled only on the frame strobe. The fraction is kept across a change of frequency, so the synthesized phase stays continuous through a retune.

Top module: `phase_computer`

## Requirements
- R1: A synchronous active-high reset clears `cycle_count`, `frac_carry` and `residue` to zero, and they stay zero until the first frame strobe after reset.
- R2: `freq_bcd` is eight BCD digits in hertz, most significant first: bits [31:28] hold tens of MHz and bits [3:0] hold units of Hz. On a frame strobe in transmit mode, `cycle_count` becomes the BCD value of bits [31:20] plus the fraction carry of that frame.
- R3: On a frame strobe, `residue` (five BCD digits, with bits [19:16] being the 10⁻¹-cycle digit) becomes the decimal sum of the previous residue and the increment `freq_bcd[19:0]`, taken modulo 100000.
- R4: `frac_carry` is 1 for a frame exactly when that sum reaches 100000 or more. In that frame `cycle_count` is one greater than the whole-cycle increment.
- R5: When `rx_mode` is 1 on a frame strobe, the whole-cycle increment is raised by 2 (200 kHz at 10 µs per frame). The fraction is unaffected.
- R6: Without a frame strobe, all three outputs hold their values, whatever `freq_bcd` and `rx_mode` do.
- R7: A new frequency on a frame strobe is added to the residue left by the previous frequency. The residue is not restarted.
- R8: The lowest bit of the units-of-Hz digit (`freq_bcd[0]`) is ignored, which gives 2 Hz resolution. `residue[0]` therefore stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse marking a reference frame boundary |
| rx_mode | input | 1 | 1 selects the receive format (+200 kHz), 0 selects transmit |
| freq_bcd | input | 32 | Programmed frequency, eight BCD digits in Hz |
| cycle_count | output | 12 | Whole cycles for this frame (N or N+1), three BCD digits |
| frac_carry | output | 1 | Fraction overflowed past one cycle in this frame |
| residue | output | 20 | Fractional phase residue, five BCD digits |

## Verification
All three results are registered at the clock edge that samples `frame_stb`. Each is therefore due one edge after the strobe is driven. The bench drives the strobe and its inputs on a falling edge, lowers the strobe on the next falling edge, and compares the outputs at that point, half a cycle after the edge that updated them. For the hold requirement, inputs are changed on falling edges with no strobe, and the outputs are compared several edges later against the values captured after the last strobe. For reset, the outputs are compared one edge after reset is raised.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef logic [3:0] bcd_digit_t;

    typedef struct packed {
        bcd_digit_t sum;
        logic       cout;
    } bcd_sum_t;

    // One decimal digit add with carry in; valid for a, b in 0..9.
    function automatic bcd_sum_t bcd_add_digit(bcd_digit_t a, bcd_digit_t b, logic cin);
        bcd_sum_t   r;
        logic [4:0] raw;
        raw = {1'b0, a} + {1'b0, b} + {4'b0000, cin};
        if (raw > 5'd9) begin
            r.sum  = raw[3:0] + 4'd6;
            r.cout = 1'b1;
        end else begin
            r.sum  = raw[3:0];
            r.cout = 1'b0;
        end
        return r;
    endfunction

    // Binary value of the lowest nd digits of a packed BCD word.
    function automatic int unsigned bcd_value(logic [31:0] v, int nd);
        int unsigned acc;
        acc = 0;
        for (int i = 7; i >= 0; i--) begin
            if (i < nd) acc = acc * 10 + int'(v[4*i +: 4]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/pa_bcd_inc.sv
module pa_bcd_inc
    import pa_pkg::*;
#(
    parameter int ND = 3
) (
    input  logic [4*ND-1:0] base,
    input  bcd_digit_t      addend,
    output logic [4*ND-1:0] sum,
    output logic            cout
);
    logic [ND:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < ND; i++) begin : g_dig
        bcd_sum_t   r;
        bcd_digit_t b;
        assign b = (i == 0) ? addend : 4'd0;
        always_comb r = bcd_add_digit(base[4*i +: 4], b, c[i]);
        assign sum[4*i +: 4] = r.sum;
        assign c[i+1]        = r.cout;
    end

    assign cout = c[ND];

    always_comb begin
        AST_INC_VALUE: assert (bcd_value(32'(sum), ND) + (cout ? 10**ND : 0)
                               == bcd_value(32'(base), ND) + int'(addend))
            else $error("decimal increment mismatch"); // R4
    end
endmodule

// File: rtl/pa_frac_acc.sv
module pa_frac_acc
    import pa_pkg::*;
#(
    parameter int ND = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stb,
    input  logic [4*ND-1:0] inc,
    output logic [4*ND-1:0] frac_q,
    output logic            carry_d
);
    localparam int unsigned WRAP = 10**ND;

    logic [ND:0]     c;
    logic [4*ND-1:0] sum;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < ND; i++) begin : g_dig
        bcd_sum_t r;
        always_comb r = bcd_add_digit(frac_q[4*i +: 4], inc[4*i +: 4], c[i]);
        assign sum[4*i +: 4] = r.sum;
        assign c[i+1]        = r.cout;

        AST_FRAC_DIGIT: assert property (@(posedge clk) disable iff (rst)
            frac_q[4*i +: 4] <= 4'd9); // R3
    end

    assign carry_d = c[ND];

    always_ff @(posedge clk) begin
        if (rst)      frac_q <= '0;
        else if (stb) frac_q <= sum;
    end

    AST_FRAC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(frac_q)); // R6

    AST_FRAC_SUM: assert property (@(posedge clk) disable iff (rst)
        stb |=> bcd_value(32'(frac_q), ND) + ($past(carry_d) ? WRAP : 0)
                == $past(bcd_value(32'(frac_q), ND) + bcd_value(32'(inc), ND))); // R7
endmodule

// File: rtl/phase_computer.sv
module phase_computer
    import pa_pkg::*;
#(
    parameter int INT_DIGITS  = 3,
    parameter int FRAC_DIGITS = 5,
    parameter int RX_OFFSET   = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_stb,
    input  logic                          rx_mode,
    input  logic [4*(INT_DIGITS+FRAC_DIGITS)-1:0] freq_bcd,
    output logic [4*INT_DIGITS-1:0]       cycle_count,
    output logic                          frac_carry,
    output logic [4*FRAC_DIGITS-1:0]      residue
);
    localparam int IW = 4*INT_DIGITS;
    localparam int FW = 4*FRAC_DIGITS;
    localparam int TW = IW + FW;
    localparam bcd_digit_t RX_DIG = bcd_digit_t'(RX_OFFSET);

    logic [IW-1:0] int_in;
    logic [FW-1:0] frac_in;
    logic [IW-1:0] int_adj;
    logic [IW-1:0] int_next;
    logic          adj_ovf;
    logic          inc_ovf;
    logic          carry_d;

    assign int_in  = freq_bcd[TW-1 -: IW];
    assign frac_in = {freq_bcd[FW-1:1], 1'b0};

    pa_bcd_inc #(.ND(INT_DIGITS)) u_rx_off (
        .base   (int_in),
        .addend (rx_mode ? RX_DIG : 4'd0),
        .sum    (int_adj),
        .cout   (adj_ovf)
    );

    pa_frac_acc #(.ND(FRAC_DIGITS)) u_frac (
        .clk     (clk),
        .rst     (rst),
        .stb     (frame_stb),
        .inc     (frac_in),
        .frac_q  (residue),
        .carry_d (carry_d)
    );

    pa_bcd_inc #(.ND(INT_DIGITS)) u_carry_add (
        .base   (int_adj),
        .addend ({3'b000, carry_d}),
        .sum    (int_next),
        .cout   (inc_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_count <= '0;
            frac_carry  <= 1'b0;
        end else if (frame_stb) begin
            cycle_count <= int_next;
            frac_carry  <= carry_d;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (cycle_count == '0 && !frac_carry && residue == '0)); // R1

    AST_EVEN_RESIDUE: assert property (@(posedge clk) disable iff (rst)
        residue[0] == 1'b0); // R8

    AST_NO_INT_WRAP: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> !(adj_ovf || inc_ovf)); // R2

    AST_TX_COUNT: assert property (@(posedge clk) disable iff (rst)
        frame_stb && !rx_mode |=> bcd_value(32'(cycle_count), INT_DIGITS)
            == $past(bcd_value(32'(int_in), INT_DIGITS)) + (frac_carry ? 1 : 0)); // R4

    AST_RX_COUNT: assert property (@(posedge clk) disable iff (rst)
        frame_stb && rx_mode |=> bcd_value(32'(cycle_count), INT_DIGITS)
            == $past(bcd_value(32'(int_in), INT_DIGITS)) + RX_OFFSET + (frac_carry ? 1 : 0)); // R5
endmodule

// File: tb/sim_phase_computer.sv
module sim_phase_computer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic        rx_mode = 1'b0;
    logic [31:0] freq_bcd = '0;
    logic [11:0] cycle_count;
    logic        frac_carry;
    logic [19:0] residue;

    int checks = 0;
    int errors = 0;
    int unsigned m_frac = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_computer u0 (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_mode(rx_mode),
        .freq_bcd(freq_bcd), .cycle_count(cycle_count),
        .frac_carry(frac_carry), .residue(residue)
    );

    function automatic logic [31:0] to_bcd(int unsigned v);
        logic [31:0] r = '0;
        for (int i = 0; i < 8; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One frame with frequency f (Hz) and mode; compares against the bench model.
    task automatic frame(string req, int unsigned f, bit rx);
        int unsigned fe, sum, cnt;
        bit cy;
        @(negedge clk);
        freq_bcd  = to_bcd(f);
        rx_mode   = rx;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        fe  = f - (f % 2);
        sum = m_frac + fe % 100000;
        cy  = (sum >= 100000);
        m_frac = sum % 100000;
        cnt = fe / 100000 + (rx ? 2 : 0) + (cy ? 1 : 0);
        chk(req, 32'(residue), to_bcd(m_frac));
        chk(req, 32'(frac_carry), 32'(cy));
        chk(req, 32'(cycle_count), to_bcd(cnt));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [35:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", {cycle_count, frac_carry, residue}, 32'h0);

        // R2 R3 R4: 42.123 MHz gives 421.23 per frame, fifth frame carries
        frame("R2", 42123000, 1'b0);
        chk("R3", 32'(residue), 32'h23000);
        frame("R3", 42123000, 1'b0);
        chk("R3", 32'(residue), 32'h46000);
        frame("R3", 42123000, 1'b0);
        frame("R3", 42123000, 1'b0);
        frame("R4", 42123000, 1'b0);
        chk("R4", {20'h0, cycle_count}, 32'h422);
        chk("R4", 32'(residue), 32'h15000);

        // R5: receive mode adds two whole cycles
        frame("R5", 70000000, 1'b1);
        chk("R5", {20'h0, cycle_count}, 32'h702);
        frame("R5", 70199998, 1'b1);

        // R6: no strobe, inputs wiggle, outputs hold
        held = {cycle_count, frac_carry, residue, 3'b0};
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            freq_bcd = to_bcd(50000000 + $urandom % 1000000);
            rx_mode  = ~rx_mode;
        end
        @(negedge clk);
        chk("R6", {cycle_count, frac_carry, residue}, held[35:3]);

        // R7: retune keeps residue
        frame("R7", 55555550, 1'b0);
        frame("R7", 61234560, 1'b0);

        // R8: odd units-of-Hz digit treated as even
        frame("R8", 42000001, 1'b0);
        frame("R8", 42000009, 1'b1);
        chk("R8", 32'(residue[0]), 32'h0);

        // R1: reset mid-run clears the residue
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", {cycle_count, frac_carry, residue}, 32'h0);
        m_frac = 0;
        frame("R1", 48765430, 1'b0);

        // Random frames, with gaps between strobes
        for (int n = 0; n < 400; n++) begin
            int unsigned f;
            f = 42000000 + ($urandom % 28000001);
            frame((n % 2 == 0) ? "R3" : "R4", f, 1'($urandom % 2));
            repeat ($urandom % 3) @(negedge clk);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule